// File: doc/BRIEF.md
# Lead-PC Slice Cache

This block holds address-computation slices that an upstream extractor has built. Each slice is a short run of instruction words, from one to sixteen of them, filed under the PC of its first (lead) instruction. The extractor writes a slice by presenting the lead PC, a word count and the words packed oldest-first. The storage is set-associative, with 256 sets of 4 ways by default, which gives 1K entries. A slice is selected by PC bits above the word offset, and each lead PC owns at most one entry.

The decode stage probes the cache with every decoded PC. On a hit the block picks the lowest-numbered helper execution unit that reports itself idle. It then streams the stored words to that unit, oldest first, one per cycle, and flags the final word. If no unit is idle, or a read-out is already under way, the hit is reported as dropped and nothing is streamed. Executing the slice and copying rename state are left to the helper units.

Top module: `lead_slice_cache`

## Requirements
- R1: After reset, spawn_hit, spawn_drop and out_valid are low and out_unit is zero, and a probe of any PC misses.
- R2: A write with 1 <= wr_count <= MAX_LEN stores the slice under wr_pc. A probe of that PC presented in cycle t, with a unit idle and no read-out active, raises spawn_hit and shows the first word in cycle t+2.
- R3: Read-out gives exactly wr_count words on consecutive cycles, word k taken from wr_words[k*INSN_W +: INSN_W], starting at k=0. out_last is high only with the final word, and out_valid falls in the cycle after it.
- R4: The read-out goes to the lowest-numbered unit whose unit_idle bit is set in cycle t+1. out_unit is one-hot on that bit, and out_lead_pc equals the probed PC, for as long as out_valid is high.
- R5: A hit finding no idle unit (unit_idle all zero in cycle t+1), or a read-out still active in cycle t+1, raises spawn_hit and spawn_drop together in cycle t+2 and starts no read-out.
- R6: Writing again to a lead PC that is already stored replaces its words and count in place. Later probes return only the new slice.
- R7: A write and a probe of the same PC in the same cycle: the probe sees the contents from before the write. It misses if the PC was absent, and returns the old slice if the PC was present.
- R8: The set index is pc[OFS +: log2(SETS)]. Within a set, new leads take ways in round-robin order. A fifth distinct lead written to a full set evicts the first one written, and the other three still hit.
- R9: A write with wr_count of 0 or above MAX_LEN is ignored. It neither creates an entry nor alters an existing one.
- R10: A probe of a PC that is not stored raises neither spawn_hit nor spawn_drop and starts no read-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Slice write strobe |
| wr_pc | input | PC_W | Lead PC of the slice being written |
| wr_count | input | CNT_W | Number of words in the slice |
| wr_words | input | MAX_LEN*INSN_W | Slice words, word 0 (oldest) in the low bits |
| probe_valid | input | 1 | Probe strobe from decode |
| probe_pc | input | PC_W | Decoded PC to look up |
| unit_idle | input | N_UNITS | One bit per helper unit, set when the unit is idle |
| spawn_hit | output | 1 | Pulse: the probe two cycles earlier hit |
| spawn_drop | output | 1 | Pulse: that hit was discarded |
| out_valid | output | 1 | A slice word is being delivered |
| out_last | output | 1 | The current word is the slice's final word |
| out_insn | output | INSN_W | Current slice word |
| out_unit | output | N_UNITS | One-hot target unit of the read-out |
| out_lead_pc | output | PC_W | Lead PC of the slice being delivered |

## Verification
The bench builds the block with its default parameters: 256 sets, 4 ways, 16-word slices, 32-bit PCs and 4 helper units. With these values, PCs 0x400 apart fall in the same set, so set conflicts, round-robin eviction after the fourth way and in-place overwrites can all be exercised with a handful of addresses. The unit vector is narrow enough to try every idle pattern of interest, including none idle. The 16-word limit lets both length extremes, 1 and 16, be streamed alongside an out-of-range count of 17.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Index of the set bit in a one-hot (or zero) vector of up to 32 bits.
  function automatic int unsigned oh_to_idx(input logic [31:0] oh);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int PC_W = 32,
  parameter int SETS = 256,
  parameter int WAYS = 4,
  parameter int OFS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_req,
  input  logic [PC_W-1:0]         wr_pc,
  input  logic [PC_W-1:0]         pr_pc,
  output logic [$clog2(WAYS)-1:0] wr_way,
  output logic                    pr_hit,
  output logic [$clog2(WAYS)-1:0] pr_way
);
  import sc_pkg::*;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] w_set, p_set;
  logic [WAYS-1:0]  w_match, p_match;
  logic [WAY_W-1:0] rr_q [SETS];

  assign w_set = wr_pc[OFS +: IDX_W];
  assign p_set = pr_pc[OFS +: IDX_W];

  // Full PC kept as tag; tag array reads asynchronously (distributed RAM).
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [PC_W-1:0] tag_mem [SETS];
    logic [SETS-1:0] vld_q;
    always_ff @(posedge clk) begin
      if (wr_req && wr_way == WAY_W'(w)) tag_mem[w_set] <= wr_pc;
    end
    always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else if (wr_req && wr_way == WAY_W'(w)) vld_q[w_set] <= 1'b1;
    end
    assign w_match[w] = vld_q[w_set] && (tag_mem[w_set] == wr_pc);
    assign p_match[w] = vld_q[p_set] && (tag_mem[p_set] == pr_pc);
  end

  // Existing lead is overwritten in place; otherwise the set's pointer picks.
  always_comb begin
    if (|w_match) wr_way = WAY_W'(oh_to_idx(32'(w_match)));
    else          wr_way = rr_q[w_set];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (wr_req && !(|w_match)) begin
      rr_q[w_set] <= rr_q[w_set] + WAY_W'(1);
    end
  end

  assign pr_hit = |p_match;
  assign pr_way = WAY_W'(oh_to_idx(32'(p_match)));

  assert_one_entry_per_lead_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(w_match) && $onehot0(p_match));
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int DW   = 517,
  parameter int SETS = 256,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [DW-1:0]           wr_data,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic [WAYS*DW-1:0]      rd_data
);
  localparam int WAY_W = $clog2(WAYS);

  // One read-first block RAM per way; all ways read in parallel.
  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [DW-1:0] mem [SETS];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      rd_q <= mem[rd_set];
      if (we && wr_way == WAY_W'(w)) mem[wr_set] <= wr_data;
    end
    assign rd_data[w*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/sc_first_idle.sv
module sc_first_idle #(
  parameter int N = 4
) (
  input  logic [N-1:0] idle,
  output logic [N-1:0] sel
);
  // Descending scan so the lowest idle index is the one left standing.
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (idle[i]) sel = N'(1) << i;
    end
  end
endmodule

// File: rtl/sc_streamer.sv
module sc_streamer #(
  parameter int PC_W    = 32,
  parameter int INSN_W  = 32,
  parameter int MAX_LEN = 16,
  parameter int N_UNITS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [MAX_LEN*INSN_W-1:0]    ld_words,
  input  logic [$clog2(MAX_LEN+1)-1:0] ld_count,
  input  logic [N_UNITS-1:0]           ld_unit,
  input  logic [PC_W-1:0]              ld_pc,
  output logic                         out_valid,
  output logic                         out_last,
  output logic [INSN_W-1:0]            out_insn,
  output logic [N_UNITS-1:0]           out_unit,
  output logic [PC_W-1:0]              out_pc
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int SW    = MAX_LEN * INSN_W;

  logic [SW-1:0]    sbuf_q;
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      out_unit <= '0;
    end else if (start) begin
      sbuf_q   <= ld_words;
      remain_q <= ld_count;
      out_unit <= ld_unit;
      out_pc   <= ld_pc;
    end else if (remain_q != '0) begin
      sbuf_q   <= sbuf_q >> INSN_W;
      remain_q <= remain_q - CNT_W'(1);
      if (remain_q == CNT_W'(1)) out_unit <= '0;
    end
  end

  assign out_valid = (remain_q != '0);
  assign out_last  = (remain_q == CNT_W'(1));
  assign out_insn  = sbuf_q[INSN_W-1:0];

  assert_stream_gapless_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);
  assert_stream_ends_R3: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);
  assert_no_restart_busy_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> !out_valid);
  assert_unit_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot(out_unit));
endmodule

// File: rtl/lead_slice_cache.sv
module lead_slice_cache #(
  parameter int PC_W    = 32,
  parameter int INSN_W  = 32,
  parameter int MAX_LEN = 16,
  parameter int SETS    = 256,
  parameter int WAYS    = 4,
  parameter int N_UNITS = 4,
  parameter int OFS     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_valid,
  input  logic [PC_W-1:0]              wr_pc,
  input  logic [$clog2(MAX_LEN+1)-1:0] wr_count,
  input  logic [MAX_LEN*INSN_W-1:0]    wr_words,
  input  logic                         probe_valid,
  input  logic [PC_W-1:0]              probe_pc,
  input  logic [N_UNITS-1:0]           unit_idle,
  output logic                         spawn_hit,
  output logic                         spawn_drop,
  output logic                         out_valid,
  output logic                         out_last,
  output logic [INSN_W-1:0]            out_insn,
  output logic [N_UNITS-1:0]           out_unit,
  output logic [PC_W-1:0]              out_lead_pc
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int SW    = MAX_LEN * INSN_W;
  localparam int DW    = SW + CNT_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic               wr_ok;
  logic [WAY_W-1:0]   wr_way, pr_way, pway_q;
  logic               pr_hit, pv_q;
  logic [PC_W-1:0]    ppc_q;
  logic [WAYS*DW-1:0] rd_data;
  logic [DW-1:0]      sel_word;
  logic [N_UNITS-1:0] pick;
  logic               accept;

  assign wr_ok = wr_valid && (wr_count != '0) && (wr_count <= CNT_W'(MAX_LEN));

  sc_tag_store #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .OFS(OFS)) u_tags (
    .clk(clk), .rst(rst), .wr_req(wr_ok), .wr_pc(wr_pc), .pr_pc(probe_pc),
    .wr_way(wr_way), .pr_hit(pr_hit), .pr_way(pr_way));

  sc_data_store #(.DW(DW), .SETS(SETS), .WAYS(WAYS)) u_data (
    .clk(clk), .we(wr_ok), .wr_way(wr_way), .wr_set(wr_pc[OFS +: IDX_W]),
    .wr_data({wr_count, wr_words}), .rd_set(probe_pc[OFS +: IDX_W]),
    .rd_data(rd_data));

  // Stage 1: register the lookup result alongside the RAM read.
  always_ff @(posedge clk) begin
    if (rst) pv_q <= 1'b0;
    else     pv_q <= probe_valid && pr_hit;
    ppc_q  <= probe_pc;
    pway_q <= pr_way;
  end

  assign sel_word = rd_data[pway_q*DW +: DW];

  sc_first_idle #(.N(N_UNITS)) u_pick (.idle(unit_idle), .sel(pick));

  assign accept = pv_q && (|unit_idle) && !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      spawn_hit  <= 1'b0;
      spawn_drop <= 1'b0;
    end else begin
      spawn_hit  <= pv_q;
      spawn_drop <= pv_q && !accept;
    end
  end

  sc_streamer #(.PC_W(PC_W), .INSN_W(INSN_W), .MAX_LEN(MAX_LEN), .N_UNITS(N_UNITS)) u_stream (
    .clk(clk), .rst(rst), .start(accept), .ld_words(sel_word[SW-1:0]),
    .ld_count(sel_word[DW-1 -: CNT_W]), .ld_unit(pick), .ld_pc(ppc_q),
    .out_valid(out_valid), .out_last(out_last), .out_insn(out_insn),
    .out_unit(out_unit), .out_pc(out_lead_pc));

  assert_drop_implies_hit_R5: assert property (@(posedge clk) disable iff (rst)
    spawn_drop |-> spawn_hit);
  assert_spawn_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && ((out_unit & ~$past(unit_idle)) == '0)));
  assert_lowest_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (|unit_idle) |-> ($onehot(pick) && (((pick - N_UNITS'(1)) & unit_idle) == '0)));
  assert_stream_has_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (spawn_hit && !spawn_drop));
endmodule

// File: tb/tb_lead_slice_cache.sv
module tb_lead_slice_cache;
  localparam int MAXL = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 1'b0, probe_valid = 1'b0;
  logic [31:0] wr_pc = '0, probe_pc = '0;
  logic [4:0] wr_count = '0;
  logic [MAXL*32-1:0] wr_words = '0;
  logic [3:0] unit_idle = 4'b1111;
  logic spawn_hit, spawn_drop, out_valid, out_last;
  logic [31:0] out_insn, out_lead_pc;
  logic [3:0] out_unit;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  lead_slice_cache dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_pc(wr_pc), .wr_count(wr_count),
    .wr_words(wr_words), .probe_valid(probe_valid), .probe_pc(probe_pc),
    .unit_idle(unit_idle), .spawn_hit(spawn_hit), .spawn_drop(spawn_drop),
    .out_valid(out_valid), .out_last(out_last), .out_insn(out_insn),
    .out_unit(out_unit), .out_lead_pc(out_lead_pc));

  always #2 clk = ~clk;

  function automatic logic [31:0] mkw(input int seed, input int k);
    return 32'((seed << 16) | 32'h5A00 | k);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_write(input logic [31:0] pc, input int cnt, input int seed);
    wr_valid = 1'b1; wr_pc = pc; wr_count = 5'(cnt);
    for (int k = 0; k < MAXL; k++) wr_words[k*32 +: 32] = (k < cnt) ? mkw(seed, k) : 32'h0;
  endtask

  task automatic write_slice(input logic [31:0] pc, input int cnt, input int seed);
    @(negedge clk); set_write(pc, cnt, seed);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // Called just after the second edge following the probe cycle.
  task automatic probe_check(input logic [31:0] pc, input bit ehit, input bit edrop,
                             input int len, input int seed, input logic [3:0] eunit, input string req);
    chk(req, "spawn_hit", 32'(spawn_hit), 32'(ehit));
    chk(req, "spawn_drop", 32'(spawn_drop), 32'(edrop));
    if (len == 0) begin
      chk(req, "no read-out", 32'(out_valid), 32'd0);
    end else begin
      for (int k = 0; k < len; k++) begin
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "word", out_insn, mkw(seed, k));
        chk(req, "out_last", 32'(out_last), 32'(k == len - 1));
        if (k == 0) begin
          chk(req, "out_unit", 32'(out_unit), 32'(eunit));
          chk(req, "out_lead_pc", out_lead_pc, pc);
        end
        @(negedge clk);
      end
      chk(req, "out_valid falls", 32'(out_valid), 32'd0);
    end
  endtask

  task automatic probe_run(input logic [31:0] pc, input bit ehit, input bit edrop,
                           input int len, input int seed, input logic [3:0] eunit, input string req);
    @(negedge clk); probe_valid = 1'b1; probe_pc = pc;
    @(negedge clk); probe_valid = 1'b0;
    @(negedge clk);
    probe_check(pc, ehit, edrop, len, seed, eunit, req);
  endtask

  task automatic t_reset;
    chk("R1", "hit after reset", 32'(spawn_hit), 32'd0);
    chk("R1", "drop after reset", 32'(spawn_drop), 32'd0);
    chk("R1", "valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "unit after reset", 32'(out_unit), 32'd0);
    probe_run(32'h2000, 0, 0, 0, 0, 4'b0000, "R1");
  endtask

  task automatic t_basic;
    write_slice(32'h2000, 5, 1);
    unit_idle = 4'b1111;
    probe_run(32'h2000, 1, 0, 5, 1, 4'b0001, "R2");
  endtask

  task automatic t_pick;
    unit_idle = 4'b1100; probe_run(32'h2000, 1, 0, 5, 1, 4'b0100, "R4");
    unit_idle = 4'b1000; probe_run(32'h2000, 1, 0, 5, 1, 4'b1000, "R4");
    unit_idle = 4'b1111;
  endtask

  task automatic t_drop_idle;
    unit_idle = 4'b0000;
    probe_run(32'h2000, 1, 1, 0, 0, 4'b0000, "R5");
    unit_idle = 4'b1111;
  endtask

  task automatic t_drop_busy;
    @(negedge clk); probe_valid = 1'b1; probe_pc = 32'h2000;
    @(negedge clk);
    @(negedge clk); probe_valid = 1'b0;
    chk("R5", "first hit", 32'(spawn_hit), 32'd1);
    chk("R5", "first not dropped", 32'(spawn_drop), 32'd0);
    chk("R5", "first word", out_insn, mkw(1, 0));
    @(negedge clk);
    chk("R5", "second hit", 32'(spawn_hit), 32'd1);
    chk("R5", "second dropped while busy", 32'(spawn_drop), 32'd1);
    chk("R5", "stream continues", out_insn, mkw(1, 1));
    for (int i = 0; i < 10 && out_valid; i++) @(negedge clk);
    @(negedge clk);
    chk("R5", "no second read-out", 32'(out_valid), 32'd0);
  endtask

  task automatic t_lengths;
    write_slice(32'h2400, 16, 2);
    probe_run(32'h2400, 1, 0, 16, 2, 4'b0001, "R3");
    write_slice(32'h2800, 1, 3);
    probe_run(32'h2800, 1, 0, 1, 3, 4'b0001, "R3");
  endtask

  task automatic t_overwrite;
    write_slice(32'h2000, 3, 9);
    probe_run(32'h2000, 1, 0, 3, 9, 4'b0001, "R6");
    probe_run(32'h2400, 1, 0, 16, 2, 4'b0001, "R6");
  endtask

  task automatic t_same_cycle;
    @(negedge clk); set_write(32'h3000, 4, 5); probe_valid = 1'b1; probe_pc = 32'h3000;
    @(negedge clk); wr_valid = 1'b0; probe_valid = 1'b0;
    @(negedge clk);
    probe_check(32'h3000, 0, 0, 0, 0, 4'b0000, "R7");
    probe_run(32'h3000, 1, 0, 4, 5, 4'b0001, "R7");
    @(negedge clk); set_write(32'h2000, 2, 11); probe_valid = 1'b1; probe_pc = 32'h2000;
    @(negedge clk); wr_valid = 1'b0; probe_valid = 1'b0;
    @(negedge clk);
    probe_check(32'h2000, 1, 0, 3, 9, 4'b0001, "R7");
    probe_run(32'h2000, 1, 0, 2, 11, 4'b0001, "R7");
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 5; k++) write_slice(32'h8004 + 32'(k) * 32'h400, 2, 20 + k);
    probe_run(32'h8004, 0, 0, 0, 0, 4'b0000, "R8");
    for (int k = 1; k < 5; k++) probe_run(32'h8004 + 32'(k) * 32'h400, 1, 0, 2, 20 + k, 4'b0001, "R8");
  endtask

  task automatic t_bad_count;
    write_slice(32'h6000, 4, 30);
    write_slice(32'h6000, 0, 31);
    probe_run(32'h6000, 1, 0, 4, 30, 4'b0001, "R9");
    write_slice(32'h5000, 17, 32);
    probe_run(32'h5000, 0, 0, 0, 0, 4'b0000, "R9");
  endtask

  task automatic t_miss;
    probe_run(32'h7777_0000, 0, 0, 0, 0, 4'b0000, "R10");
    probe_run(32'h2004, 0, 0, 0, 0, 4'b0000, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pick();
    t_drop_idle();
    t_drop_busy();
    t_lengths();
    t_overwrite();
    t_same_cycle();
    t_round_robin();
    t_bad_count();
    t_miss();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule